// File: doc/BRIEF.md
# Preset BCD Pulse-Train Generator

This block emits a burst of one-cycle pulses. The number of pulses equals a two-digit decimal value set on switch inputs in BCD. A rising edge on the start input makes the block load the setting into a chain of BCD down counters. A four-state controller then alternates between a pulse cycle and a gap cycle. It steps the counters down by one for every pulse until both digits read zero. The counters flag zero through an active-low end output, and that flag sends the controller back to idle.

The controller and its outputs change on the rising clock edge. The counters load and decrement on the falling edge, so each counter change falls in the middle of a controller cycle. A zero setting produces no pulses. A setting with any digit above nine is refused, so no load takes place and no burst starts. Only one burst is produced for each press of start. Start must go low and then high again before another burst can begin.

Top module: `bcd_pulse_gen`

## Requirements
- R1: While reset is high and in the cycle after it, state_o is 2'b00 (idle), load_o, cnt_en_o and pulse_o are 0, and end_n_o is 0 because the counters are cleared to zero.
- R2: When start_i rises while the block is idle and both digits are valid, the next rising edge moves the block to the load state (state_o = 2'b01) for exactly one cycle with load_o = 1.
- R3: The counters take the setting on the falling edge inside the load cycle. The load state is always followed by one full gap cycle (state_o = 2'b11) with cnt_en_o and pulse_o at 0, before any count enable or pulse.
- R4: A pulse cycle (state_o = 2'b10) drives pulse_o and cnt_en_o high for exactly one cycle and is always followed by a gap cycle. The counters decrement on the falling edge inside that cycle.
- R5: For a valid setting, the number of pulses in a burst equals 10·setting_i[7:4] + setting_i[3:0]. Bits [7:4] hold the tens digit and bits [3:0] hold the units digit.
- R6: When the units counter decrements from 0 it wraps to 9 and borrows, and only that borrow decrements the tens counter. Settings such as 10 and 99 therefore give exactly 10 and 99 pulses.
- R7: end_n_o is 0 exactly when both counter digits are zero. In a gap cycle with end_n_o = 0 the block returns to idle without a pulse, so a setting of 00 gives a load but zero pulses.
- R8: If either digit of setting_i is in the range 10 to 15 when start_i rises, load_o stays 0, no pulse is issued and state_o stays 2'b00.
- R9: A burst starts only on a rising edge of start_i seen in idle. Holding start_i high past the end of a burst, or toggling it during a burst, neither starts a second burst nor changes the pulse count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The controller uses the rising edge and the counters use the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request. A burst begins on its rising edge |
| setting_i | input | 8 | BCD setting: tens digit in [7:4], units digit in [3:0] |
| load_o | output | 1 | Load strobe to the counters |
| cnt_en_o | output | 1 | Count enable. The counters decrement while it is high |
| pulse_o | output | 1 | Output pulse, one cycle per count |
| end_n_o | output | 1 | Active low. Low when both counter digits are zero |
| state_o | output | 2 | Controller state: 00 idle, 01 load, 11 gap, 10 pulse |

## Verification
The assertions take setting_i as held steady from the rising edge of start until the burst has ended. They also take start_i as a level that changes only between clock edges, as a debounced and synchronised switch would be. The bench keeps to this: it sets the digits before it raises start, and it changes start_i and setting_i only a short time after a rising edge. Inside that rule the bench still toggles start in the middle of a burst, holds start high past the end of a burst, and tries settings whose tens digit, units digit or both are out of range.

// File: rtl/bcd_pulse_pkg.sv
package bcd_pulse_pkg;

    // Two-bit controller encoding; neighbours step by one bit.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_LOAD  = 2'b01,
        ST_GAP   = 2'b11,
        ST_PULSE = 2'b10
    } ctrl_state_e;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    localparam bcd_digit_t BCD_TOP = 4'd9;

    typedef struct packed {
        logic load;
        logic cnt;
        logic pulse;
    } ctrl_out_t;

    function automatic logic digit_ok(input bcd_digit_t d);
        return d <= BCD_TOP;
    endfunction

    function automatic bcd_digit_t digit_dec(input bcd_digit_t d);
        return (d == '0) ? BCD_TOP : d - 1'b1;
    endfunction

    function automatic ctrl_out_t decode_out(input ctrl_state_e s);
        ctrl_out_t o;
        o.load  = (s == ST_LOAD);
        o.cnt   = (s == ST_PULSE);
        o.pulse = (s == ST_PULSE);
        return o;
    endfunction

endpackage

// File: rtl/bcd_down_digit.sv
module bcd_down_digit
    import bcd_pulse_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic       en_i,
    input  bcd_digit_t preset_i,
    output bcd_digit_t q_o,
    output logic       borrow_o
);

    bcd_digit_t q;

    // Falling-edge register: loads and steps half a cycle after the controller.
    always_ff @(negedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load_i) begin
            q <= preset_i;
        end else if (en_i) begin
            q <= digit_dec(q);
        end
    end

    assign q_o      = q;
    assign borrow_o = en_i && (q == '0);

endmodule

// File: rtl/bcd_down_chain.sv
module bcd_down_chain
    import bcd_pulse_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int VW    = DIGITS * DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          cnt_i,
    input  logic [VW-1:0] preset_i,
    output logic          zero_o,
    output logic          preset_ok_o
);

    logic [DIGITS:0]     en_chain;
    logic [DIGITS-1:0]   dig_zero;
    logic [DIGITS-1:0]   dig_ok;

    assign en_chain[0] = cnt_i;

    // Digit 0 is the units digit; each borrow enables the next digit up.
    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        bcd_digit_t q;

        bcd_down_digit u_digit (
            .clk      (clk),
            .rst      (rst),
            .load_i   (load_i),
            .en_i     (en_chain[i]),
            .preset_i (preset_i[i*DIGIT_W +: DIGIT_W]),
            .q_o      (q),
            .borrow_o (en_chain[i+1])
        );

        assign dig_zero[i] = (q == '0);
        assign dig_ok[i]   = digit_ok(preset_i[i*DIGIT_W +: DIGIT_W]);
    end

    assign zero_o      = &dig_zero;
    assign preset_ok_o = &dig_ok;

endmodule

// File: rtl/bcd_pulse_ctrl.sv
module bcd_pulse_ctrl
    import bcd_pulse_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        preset_ok_i,
    input  logic        end_n_i,
    output ctrl_out_t   ctl_o,
    output ctrl_state_e state_o
);

    ctrl_state_e state, state_nx;
    logic        start_q;
    logic        start_rise;

    assign start_rise = start_i && !start_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start_rise && preset_ok_i) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = ST_GAP;
            ST_GAP:   state_nx = end_n_i ? ST_PULSE : ST_IDLE;
            ST_PULSE: state_nx = ST_GAP;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= state_nx;
            start_q <= start_i;
        end
    end

    assign ctl_o   = decode_out(state);
    assign state_o = state;

endmodule

// File: rtl/bcd_pulse_gen.sv
module bcd_pulse_gen
    import bcd_pulse_pkg::*;
#(
    parameter int DIGITS = 2,
    localparam int VW    = DIGITS * DIGIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [VW-1:0] setting_i,
    output logic          load_o,
    output logic          cnt_en_o,
    output logic          pulse_o,
    output logic          end_n_o,
    output logic [1:0]    state_o
);

    ctrl_out_t   ctl;
    ctrl_state_e state;
    logic        zero;
    logic        preset_ok;

    bcd_pulse_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .preset_ok_i (preset_ok),
        .end_n_i     (!zero),
        .ctl_o       (ctl),
        .state_o     (state)
    );

    bcd_down_chain #(.DIGITS(DIGITS)) u_chain (
        .clk         (clk),
        .rst         (rst),
        .load_i      (ctl.load),
        .cnt_i       (ctl.cnt),
        .preset_i    (setting_i),
        .zero_o      (zero),
        .preset_ok_o (preset_ok)
    );

    assign load_o   = ctl.load;
    assign cnt_en_o = ctl.cnt;
    assign pulse_o  = ctl.pulse;
    assign end_n_o  = !zero;
    assign state_o  = state;

endmodule

// File: rtl/bcd_pulse_chk.sv
module bcd_pulse_chk #(
    parameter int DIGITS = 2,
    localparam int VW    = DIGITS * 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [VW-1:0] setting_i,
    input logic          load_o,
    input logic          cnt_en_o,
    input logic          pulse_o,
    input logic          end_n_o,
    input logic [1:0]    state_o
);

    logic any_bad;
    always_comb begin
        any_bad = 1'b0;
        for (int i = 0; i < DIGITS; i++) begin
            if (setting_i[i*4 +: 4] > 4'd9) any_bad = 1'b1;
        end
    end

    // R2
    load_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> ($past(state_o) == 2'b00 && $past(start_i)));

    // R3
    gap_after_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |=> (state_o == 2'b11 && !cnt_en_o && !pulse_o));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> (!pulse_o && state_o == 2'b11));

    // R7
    end_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11 && !end_n_o) |=> (state_o == 2'b00 && !pulse_o));

    // R7
    nonzero_pulses_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b11 && end_n_o) |=> pulse_o);

    // R8
    bad_digit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'b00 && any_bad) |=> (!load_o && state_o == 2'b00));

endmodule

bind bcd_pulse_gen bcd_pulse_chk #(.DIGITS(DIGITS)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .setting_i (setting_i),
    .load_o    (load_o),
    .cnt_en_o  (cnt_en_o),
    .pulse_o   (pulse_o),
    .end_n_o   (end_n_o),
    .state_o   (state_o)
);

// File: tb/test_bcd_pulse_gen.sv
`timescale 1ns/1ps
module test_bcd_pulse_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic [7:0] setting_i;
    logic       load_o, cnt_en_o, pulse_o, end_n_o;
    logic [1:0] state_o;

    int total = 0;
    int bad   = 0;
    int pulse_seen = 0;
    int load_seen  = 0;

    typedef struct {
        int    exp;
        string req;
    } sb_item_t;
    sb_item_t exp_q[$];

    always #4 clk = ~clk;

    bcd_pulse_gen i_bcd_pulse_gen (
        .clk(clk), .rst(rst), .start_i(start_i), .setting_i(setting_i),
        .load_o(load_o), .cnt_en_o(cnt_en_o), .pulse_o(pulse_o),
        .end_n_o(end_n_o), .state_o(state_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // Monitor: counts pulses and loads, then scores against the queue.
    always @(posedge clk) begin
        #3;
        if (pulse_o) pulse_seen++;
        if (load_o)  load_seen++;
    end

    initial begin
        forever begin
            sb_item_t it;
            wait (exp_q.size() > 0);
            it = exp_q.pop_front();
            chk(pulse_seen == it.exp, it.req, pulse_seen, it.exp);
        end
    end

    // Driver: one burst; toggle_at > 0 drops and re-raises start mid-burst.
    task automatic burst(input logic [7:0] s, input int exp, input string req,
                         input bit hold, input int toggle_at);
        int n;
        setting_i  = s;
        step();
        pulse_seen = 0;
        load_seen  = 0;
        start_i    = 1'b1;
        n = 0;
        repeat (240) begin
            step();
            n++;
            if (!hold && toggle_at == 0) start_i = 1'b0;
            if (toggle_at > 0 && n == toggle_at)     start_i = 1'b0;
            if (toggle_at > 0 && n == toggle_at + 1) start_i = 1'b1;
            if (state_o == 2'b00) break;
        end
        repeat (20) step();
        start_i = 1'b0;
        step();
        exp_q.push_back('{exp, req});
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start_i = 1'b0; setting_i = 8'h00;
        repeat (3) step();
        // R1 reset state
        chk(state_o == 2'b00, "R1 state", state_o, 0);
        chk({load_o, cnt_en_o, pulse_o} == 3'b000, "R1 outputs", {load_o, cnt_en_o, pulse_o}, 0);
        chk(end_n_o == 1'b0, "R1 end_n", end_n_o, 0);
        rst = 1'b0;
        step();
        chk(state_o == 2'b00 && !load_o, "R1 after release", state_o, 0);

        // Detailed timing with 03
        setting_i = 8'h03;
        step();
        start_i = 1'b1;
        step();
        chk(load_o && state_o == 2'b01, "R2 load cycle", {state_o, load_o}, 3);
        start_i = 1'b0;
        step();
        chk(state_o == 2'b11 && !cnt_en_o && !pulse_o, "R3 gap after load", {state_o, cnt_en_o, pulse_o}, 12);
        chk(end_n_o == 1'b1, "R3 counters loaded", end_n_o, 1);
        step();
        chk(state_o == 2'b10 && pulse_o && cnt_en_o, "R4 pulse cycle", {state_o, cnt_en_o, pulse_o}, 11);
        step();
        chk(state_o == 2'b11 && !pulse_o, "R4 gap follows pulse", {state_o, pulse_o}, 6);
        repeat (4) step();
        chk(state_o == 2'b11 && end_n_o == 1'b0, "R7 end flag at zero", {state_o, end_n_o}, 6);
        step();
        chk(state_o == 2'b00 && !pulse_o, "R7 back to idle", state_o, 0);
        repeat (3) step();

        // Scoreboard bursts
        burst(8'h03, 3,  "R5 count 03", 1'b0, 0);
        burst(8'h01, 1,  "R5 count 01", 1'b0, 0);
        burst(8'h45, 45, "R5 count 45", 1'b0, 0);
        burst(8'h10, 10, "R6 borrow 10", 1'b0, 0);
        burst(8'h99, 99, "R6 count 99", 1'b0, 0);
        burst(8'h00, 0,  "R7 count 00", 1'b0, 0);
        chk(load_seen == 1, "R7 00 still loads", load_seen, 1);
        burst(8'h0A, 0,  "R8 units 1010", 1'b0, 0);
        chk(load_seen == 0, "R8 no load units", load_seen, 0);
        burst(8'hF3, 0,  "R8 tens 1111", 1'b0, 0);
        chk(load_seen == 0, "R8 no load tens", load_seen, 0);
        burst(8'hCF, 0,  "R8 both bad", 1'b0, 0);
        chk(state_o == 2'b00, "R8 stays idle", state_o, 0);
        burst(8'h04, 4,  "R9 start held", 1'b1, 0);
        chk(load_seen == 1, "R9 one load held", load_seen, 1);
        burst(8'h05, 5,  "R9 start toggled", 1'b1, 4);
        chk(load_seen == 1, "R9 one load toggled", load_seen, 1);
        burst(8'h02, 2,  "R9 re-armed", 1'b0, 0);

        repeat (5) step();
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule